// File: doc/BRIEF.md
# Iterative AES Block Encryptor

This block encrypts one 128-bit block with AES. It reuses a single round datapath once per clock. It does not expand keys. Instead it drives a 4-bit round index outward, and a key store outside the block returns the matching 128-bit round key on the same cycle, with no register in between. One engine covers the 10-round schedule used with a 128-bit key and the 14-round schedule used with a 256-bit key. A one-bit select picks the schedule when the encryption starts.

To use it, the caller holds the plaintext on the block input and pulses start while ready is high. Ready then drops. When ready returns high, the output holds the ciphertext. It keeps that value until the next accepted start. Byte 0 of the state is bits 127:120. The state is read column by column, so column c holds bytes 4c to 4c+3, with row 0 first.

Top module: `aes_round_engine`

## Requirements
- R1: While reset is held, and after it is released with no start, ready_o is 1, round_idx_o is 0 and block_o is all zeros.
- R2: While idle, round_idx_o is 0. After the clock edge that accepts a start, round_idx_o steps through 1, 2, ... up to the last round (10 when key256_i was 0, 14 when it was 1), one step per clock. After the final round it returns to 0.
- R3: With key256_i = 0 the output equals AES-128 encryption of block_i under the supplied round keys. Key 2b7e151628aed2a6abf7158809cf4f3c with plaintext 6bc1bee22e409f96e93d7e117393172a gives 3ad77bb40d7a3660a89ecaf32466ef97. Byte 0 is bits 127:120, in column-major order.
- R4: With key256_i = 1 the output equals AES-256 encryption. The key 603deb1015ca71be2b73aef0857d7781_1f352c073b6108d72d9810a30914dff4 maps the same plaintext to f3eed1bdb5d2a03c064b5a7e3db181f8.
- R5: After the edge that accepts a start, ready_o stays 0. It returns to 1 after exactly 12 edges in total for the 10-round schedule and 16 edges for the 14-round schedule, counting the accepting edge.
- R6: A start pulse while ready_o is 0 has no effect. The result and the latency are those of the run already in progress.
- R7: key256_i is sampled only at the accepting edge. Changing it during a run alters neither the round count nor the result.
- R8: While ready_o is 1 and no start is given, block_o holds its value even when block_i changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an encryption; accepted only while ready_o is 1 |
| key256_i | input | 1 | Schedule select: 0 selects 10 rounds, 1 selects 14 rounds |
| round_idx_o | output | 4 | Index of the round key wanted this cycle |
| round_key_i | input | 128 | Round key for round_idx_o, supplied combinationally |
| block_i | input | 128 | Plaintext, held stable at the accepting edge |
| block_o | output | 128 | State register; holds the ciphertext once ready_o is 1 |
| ready_o | output | 1 | Idle and result valid |

## Verification
The bench builds the engine with its default round counts of 10 and 14, so it exercises both schedules in full. The bench holds its own AES reference: an S-box found by brute-force field inversion, a full key expansion for both key sizes, and byte-array round functions. With that reference it checks the two fixed vectors and a sweep of pseudo-random keys and blocks in both modes. On every run it also checks the index sequence and the latency. Dedicated runs inject a start pulse and a flip of the key-length select mid-run, and idle gaps check that the output holds.

// File: rtl/aes_eng_pkg.sv
package aes_eng_pkg;

  localparam int unsigned BLOCK_W = 128;
  localparam int unsigned NBYTES  = BLOCK_W / 8;

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_INIT  = 2'd1,
    UPD_MAIN  = 2'd2,
    UPD_FINAL = 2'd3
  } upd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } eng_state_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_fn(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox (
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  import aes_eng_pkg::*;

  always_comb byte_o = sbox_fn(byte_i);

endmodule

// File: rtl/aes_round_dp.sv
module aes_round_dp
  import aes_eng_pkg::*;
(
  input  logic [BLOCK_W-1:0] state_i,
  input  logic [BLOCK_W-1:0] key_i,
  input  upd_e               upd_i,
  output logic [BLOCK_W-1:0] state_o
);

  logic [BLOCK_W-1:0] sub_w, sr_w, mc_w;

  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_sub
    aes_sbox i_sbox (
      .byte_i(state_i[BLOCK_W-1-8*gb -: 8]),
      .byte_o(sub_w[BLOCK_W-1-8*gb -: 8])
    );
  end

  // row r of column c takes the byte from column (c+r) mod 4
  for (genvar gc = 0; gc < 4; gc++) begin : g_col
    for (genvar gr = 0; gr < 4; gr++) begin : g_row
      localparam int DST = 4*gc + gr;
      localparam int SRC = 4*((gc+gr)%4) + gr;
      assign sr_w[BLOCK_W-1-8*DST -: 8] = sub_w[BLOCK_W-1-8*SRC -: 8];
    end

    logic [7:0] a0, a1, a2, a3;
    assign a0 = sr_w[BLOCK_W-1-8*(4*gc)   -: 8];
    assign a1 = sr_w[BLOCK_W-1-8*(4*gc+1) -: 8];
    assign a2 = sr_w[BLOCK_W-1-8*(4*gc+2) -: 8];
    assign a3 = sr_w[BLOCK_W-1-8*(4*gc+3) -: 8];

    assign mc_w[BLOCK_W-1-8*(4*gc)   -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    assign mc_w[BLOCK_W-1-8*(4*gc+1) -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    assign mc_w[BLOCK_W-1-8*(4*gc+2) -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    assign mc_w[BLOCK_W-1-8*(4*gc+3) -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
  end

  always_comb begin
    unique case (upd_i)
      UPD_INIT:  state_o = state_i ^ key_i;
      UPD_MAIN:  state_o = mc_w ^ key_i;
      UPD_FINAL: state_o = sr_w ^ key_i;
      default:   state_o = state_i;
    endcase
  end

endmodule

// File: rtl/aes_round_ctrl.sv
module aes_round_ctrl
  import aes_eng_pkg::*;
#(
  parameter int unsigned ROUNDS_SHORT = 10,
  parameter int unsigned ROUNDS_LONG  = 14,
  parameter int unsigned IDX_W        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             key256_i,
  output logic [IDX_W-1:0] round_idx_o,
  output upd_e             upd_o,
  output logic             load_o,
  output logic             ready_o
);

  localparam logic [IDX_W-1:0] LAST_S = IDX_W'(ROUNDS_SHORT);
  localparam logic [IDX_W-1:0] LAST_L = IDX_W'(ROUNDS_LONG);

  eng_state_e       state_q, state_d;
  logic [IDX_W-1:0] ctr_q, ctr_d;
  logic             long_q, long_d;
  logic             last_w;

  assign last_w = (ctr_q == (long_q ? LAST_L : LAST_S));

  always_comb begin
    state_d     = state_q;
    ctr_d       = ctr_q;
    long_d      = long_q;
    upd_o       = UPD_HOLD;
    load_o      = 1'b0;
    ready_o     = 1'b0;
    round_idx_o = ctr_q;
    unique case (state_q)
      ST_IDLE: begin
        ready_o     = 1'b1;
        round_idx_o = '0;
        if (start_i) begin
          upd_o   = UPD_INIT;
          load_o  = 1'b1;
          long_d  = key256_i;
          ctr_d   = IDX_W'(1);
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        load_o = 1'b1;
        if (last_w) begin
          upd_o   = UPD_FINAL;
          ctr_d   = '0;
          state_d = ST_DONE;
        end else begin
          upd_o = UPD_MAIN;
          ctr_d = ctr_q + IDX_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ctr_q   <= '0;
      long_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ctr_q   <= ctr_d;
      long_q  <= long_d;
    end
  end

endmodule

// File: rtl/aes_round_engine.sv
module aes_round_engine
  import aes_eng_pkg::*;
#(
  parameter int unsigned ROUNDS_SHORT = 10,
  parameter int unsigned ROUNDS_LONG  = 14,
  parameter int unsigned IDX_W        = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               key256_i,
  output logic [IDX_W-1:0]   round_idx_o,
  input  logic [BLOCK_W-1:0] round_key_i,
  input  logic [BLOCK_W-1:0] block_i,
  output logic [BLOCK_W-1:0] block_o,
  output logic               ready_o
);

  upd_e               upd_w;
  logic               load_w;
  logic [BLOCK_W-1:0] block_q, dp_in_w, dp_out_w;

  aes_round_ctrl #(
    .ROUNDS_SHORT(ROUNDS_SHORT),
    .ROUNDS_LONG (ROUNDS_LONG),
    .IDX_W       (IDX_W)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .key256_i   (key256_i),
    .round_idx_o(round_idx_o),
    .upd_o      (upd_w),
    .load_o     (load_w),
    .ready_o    (ready_o)
  );

  // initial step works on the fresh input block, later rounds on the register
  assign dp_in_w = (upd_w == UPD_INIT) ? block_i : block_q;

  aes_round_dp i_dp (
    .state_i(dp_in_w),
    .key_i  (round_key_i),
    .upd_i  (upd_w),
    .state_o(dp_out_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     block_q <= '0;
    else if (load_w) block_q <= dp_out_w;
  end

  assign block_o = block_q;

endmodule

// File: rtl/aes_round_engine_chk.sv
module aes_round_engine_chk #(
  parameter int unsigned ROUNDS_SHORT = 10,
  parameter int unsigned ROUNDS_LONG  = 14,
  parameter int unsigned IDX_W        = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             key256_i,
  input logic [IDX_W-1:0] round_idx_o,
  input logic [127:0]     block_o,
  input logic             ready_o
);

  localparam int unsigned CW = 6;
  localparam logic [CW-1:0] LAT_S = CW'(ROUNDS_SHORT + 2);
  localparam logic [CW-1:0] LAT_L = CW'(ROUNDS_LONG + 2);

  logic          mode_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ready_o && start_i) begin
      mode_q <= key256_i;
      cnt_q  <= CW'(1);
    end else if (!ready_o) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  a_r2_idle_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> round_idx_o == '0);

  a_r2_idx_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !mode_q) |-> round_idx_o <= IDX_W'(ROUNDS_SHORT));

  a_r2_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && round_idx_o != '0) |=>
      (round_idx_o == $past(round_idx_o) + IDX_W'(1)) || (round_idx_o == '0));

  a_r5_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> !ready_o);

  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> cnt_q == (mode_q ? LAT_L : LAT_S));

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> $stable(block_o));

endmodule

bind aes_round_engine aes_round_engine_chk #(
  .ROUNDS_SHORT(ROUNDS_SHORT),
  .ROUNDS_LONG (ROUNDS_LONG),
  .IDX_W       (IDX_W)
) i_chk (.*);

// File: tb/test_aes_round_engine.sv
`timescale 1ns/1ps
module test_aes_round_engine;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         key256 = 1'b0;
  logic [3:0]   ridx;
  logic [127:0] rkey, blk_in, blk_out;
  logic         ready;

  logic [127:0] rk [0:14];
  logic [7:0]   sb [0:255];
  int           n_checks = 0;
  int           n_fail = 0;
  int           cyc = 0;
  logic [63:0]  rng = 64'h9e3779b97f4a7c15;

  always #2.5 clk = ~clk;

  assign rkey = rk[ridx];

  aes_round_engine i_aes_round_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .key256_i(key256),
    .round_idx_o(ridx), .round_key_i(rkey), .block_i(blk_in),
    .block_o(blk_out), .ready_o(ready)
  );

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%032h expected=%032h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] mul_ref(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i-8));
    return p[7:0];
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] o;
      for (int y = 1; y < 256; y++) if (mul_ref(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
      sb[x] = o;
    end
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  // key taken from the upper half when short
  task automatic expand(input logic long_key, input logic [255:0] key);
    logic [31:0] w [0:59];
    logic [7:0]  rc = 8'h01;
    int nk = long_key ? 8 : 4;
    int nw = long_key ? 60 : 44;
    for (int i = 0; i < nk; i++) w[i] = key[255-32*i -: 32];
    for (int i = nk; i < nw; i++) begin
      logic [31:0] t = w[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = mul_ref(rc, 8'h02);
      end else if (nk == 8 && i % nk == 4) t = subw(t);
      w[i] = w[i-nk] ^ t;
    end
    for (int r = 0; r < 15; r++)
      rk[r] = (4*r+3 < nw) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : 128'h0;
  endtask

  function automatic logic [127:0] ref_enc(input logic long_key, input logic [127:0] pt);
    logic [7:0] s [0:15];
    logic [7:0] t [0:15];
    int nr = long_key ? 14 : 10;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rk[0][127-8*i -: 8];
    for (int r = 1; r <= nr; r++) begin
      for (int i = 0; i < 16; i++) s[i] = sb[s[i]];
      for (int c = 0; c < 4; c++) for (int q = 0; q < 4; q++) t[4*c+q] = s[4*((c+q)%4)+q];
      for (int c = 0; c < 4; c++) for (int q = 0; q < 4; q++)
        if (r != nr)
          s[4*c+q] = mul_ref(t[4*c+q], 8'h02) ^ mul_ref(t[4*c+(q+1)%4], 8'h03)
                   ^ t[4*c+(q+2)%4] ^ t[4*c+(q+3)%4];
        else s[4*c+q] = t[4*c+q];
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ rk[r][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) pt[127-8*i -: 8] = s[i];
    return pt;
  endfunction

  function automatic logic [63:0] nxt(input logic [63:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    return x ^ (x << 17);
  endfunction

  task automatic rnd128(output logic [127:0] v);
    rng = nxt(rng); v[127:64] = rng;
    rng = nxt(rng); v[63:0] = rng;
  endtask

  // disturb: 0 none, 1 start pulse mid-run, 2 key-length flip mid-run
  task automatic run_enc(input logic long_key, input logic [127:0] pt, input int disturb,
                         output logic [127:0] ct, output int lat, output logic idx_ok);
    int nr = long_key ? 14 : 10;
    @(negedge clk);
    blk_in = pt; key256 = long_key; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    idx_ok = 1'b1;
    while (!ready && lat < 60) begin
      if (ridx != ((lat <= nr) ? 4'(lat) : 4'd0)) idx_ok = 1'b0;
      if (disturb == 1 && lat == 3) begin start = 1'b1; blk_in = ~pt; end
      if (disturb == 1 && lat == 4) start = 1'b0;
      if (disturb == 2 && lat == 3) key256 = ~long_key;
      @(negedge clk);
      lat++;
    end
    key256 = long_key;
    ct = blk_out;
  endtask

  task automatic one_case(input logic long_key, input logic [127:0] pt, input int disturb,
                          input logic [127:0] fixed_exp, input logic use_fixed, input string rq);
    logic [127:0] ct, exp;
    int lat;
    logic iok;
    exp = use_fixed ? fixed_exp : ref_enc(long_key, pt);
    run_enc(long_key, pt, disturb, ct, lat, iok);
    chk(ct == exp, rq, ct, exp);
    chk(lat == (long_key ? 16 : 12), "R5", 128'(lat), long_key ? 128'd16 : 128'd12);
    chk(iok, "R2", {127'b0, iok}, 128'd1);
  endtask

  initial begin
    logic [127:0] pt0, v, kh, kl, held;
    blk_in = '0;
    build_sbox();
    for (int r = 0; r < 15; r++) rk[r] = '0;
    #1;
    chk(ready === 1'b1 && ridx === 4'd0 && blk_out === 128'h0, "R1 in reset", blk_out, 128'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready === 1'b1 && ridx === 4'd0 && blk_out === 128'h0, "R1 after release",
        {blk_out[126:0], ready}, 128'h1);

    pt0 = 128'h6bc1bee22e409f96e93d7e117393172a;
    expand(1'b0, {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0});
    one_case(1'b0, pt0, 0, 128'h3ad77bb40d7a3660a89ecaf32466ef97, 1'b1, "R3 vector");
    expand(1'b1, {128'h603deb1015ca71be2b73aef0857d7781, 128'h1f352c073b6108d72d9810a30914dff4});
    chk(rk[1] == 128'h1f352c073b6108d72d9810a30914dff4, "R4 schedule", rk[1],
        128'h1f352c073b6108d72d9810a30914dff4);
    one_case(1'b1, pt0, 0, 128'hf3eed1bdb5d2a03c064b5a7e3db181f8, 1'b1, "R4 vector");

    for (int n = 0; n < 24; n++) begin
      logic lk = n[0];
      rnd128(kh); rnd128(kl); rnd128(v);
      expand(lk, {kh, kl});
      one_case(lk, v, 0, 128'h0, 1'b0, lk ? "R4 sweep" : "R3 sweep");
    end

    for (int m = 0; m < 2; m++) begin
      rnd128(kh); rnd128(kl); rnd128(v);
      expand(m[0], {kh, kl});
      one_case(m[0], v, 1, 128'h0, 1'b0, "R6 start while busy");
      one_case(m[0], v, 2, 128'h0, 1'b0, "R7 key-length flip");
    end

    held = blk_out;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rnd128(v);
      blk_in = v;
      key256 = k[0];
    end
    @(negedge clk);
    chk(blk_out == held && ready && ridx == 4'd0, "R8 idle hold", blk_out, held);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule